// File: doc/BRIEF.md
# Multi-View Floating-Point Register File

This block holds sixty-four 32-bit single-precision words in one storage array and lets a datapath reach them through four addressing views: a plain single word, a double made of two adjacent words, a four-word vector, and a matrix base word. No arithmetic is done here; the block only maps an index and a view onto storage locations and joins or splits words.

There is one write port and one read port. Each carries its own view select and index, so the two ports can use different views in the same cycle. Writes take effect on the rising clock edge, at most one write per cycle. Reads are combinational. A read and a write in the same cycle return the contents held before that edge. A synchronous, active-low reset clears every word to zero.

The view select is encoded as 0 = single, 1 = double, 2 = vector, 3 = matrix. Both data buses are 128 bits wide and are divided into four 32-bit word slots. Slot 0 is bits [31:0] and slot 3 is bits [127:96].

Top module: `fp_multiview_regfile`

## Requirements
- R1: After a cycle with `rst_n` low at the clock edge, every one of the 64 words reads as zero.
- R2: A single read (view 0) of index i returns word i in slot 0, with bits [127:32] zero.
- R3: A single write (view 0) of index i stores `wr_data[31:0]` into word i. Bits [127:32] and all other words are left untouched.
- R4: A double read (view 1) of index i returns word i in bits [63:32] and word i+1 in bits [31:0], with bits [127:64] zero.
- R5: A double write (view 1) of index i stores `wr_data[63:32]` into word i and `wr_data[31:0]` into word i+1.
- R6: In the double view, index 63 pairs with word 0 as its second word, for both reads and writes.
- R7: A vector read (view 2) keeps only the low 4 bits of the index and multiplies them by 4 to form a base b. It returns word b in bits [127:96], b+1 in [95:64], b+2 in [63:32] and b+3 in [31:0].
- R8: A vector write (view 2) stores the four slots into words b..b+3, using the same base and the same slot order as R7.
- R9: A matrix read (view 3) keeps only the low 2 bits of the index and multiplies them by 16 to form a base. It returns that word in bits [31:0], with bits [127:32] zero.
- R10: A matrix write (view 3) stores `wr_data[31:0]` into the matrix base word only.
- R11: A write becomes visible on the read port only after its clock edge. A same-cycle read returns the old contents.
- R12: While `wr_en` is low, the stored words do not change, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset, clears all words |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_view | input | 2 | Write view: 0 single, 1 double, 2 vector, 3 matrix |
| wr_idx | input | 6 | Write index, interpreted per view |
| wr_data | input | 128 | Write data in four 32-bit slots |
| rd_view | input | 2 | Read view, same encoding as `wr_view` |
| rd_idx | input | 6 | Read index, interpreted per view |
| rd_data | output | 128 | Combinational read data in four 32-bit slots |

## Verification
The assertions check on every cycle the structural rules of the mapping:
- a double at index 63 wraps to word 0;
- vector bases fall on multiples of 4 and matrix bases on multiples of 16, with the right number of active lanes;
- unused upper slots of single and double reads are zero;
- each enabled write lane lands its word one edge later;
- an idle write port leaves storage and a steady read result unchanged.

Only the bench's scenarios can show that the correct words end up in the correct slots across views. For example, a vector write read back as singles, index masking at indices beyond the view's range, reset clearing, and the old-value result of a same-cycle read. The bench compares these against an independent word-level model under both directed and random traffic.

// File: rtl/fprf_pkg.sv
// Package: shared view encoding for the multi-view register file.
// Assumes both ports use the same 2-bit view select.
package fprf_pkg;

    typedef enum logic [1:0] {
        VIEW_SINGLE = 2'd0,
        VIEW_DOUBLE = 2'd1,
        VIEW_VECTOR = 2'd2,
        VIEW_MATRIX = 2'd3
    } fp_view_e;

endpackage : fprf_pkg

// File: rtl/fprf_lane_map.sv
// Module: fprf_lane_map
// Turns a view and an index into up to LANES word addresses. For each lane it
// gives an enable and the data slot the lane uses. Lane 0 is always the base
// word. The active lanes fill the slots from the most significant one down.
// Assumes NUM_REGS, LANES and MTX_STRIDE are powers of two with LANES >= 2,
// so that address arithmetic wraps modulo NUM_REGS.
module fprf_lane_map
    import fprf_pkg::*;
#(
    parameter int NUM_REGS   = 64,
    parameter int LANES      = 4,
    parameter int MTX_STRIDE = 16,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int LANE_SH   = $clog2(LANES),
    localparam int MTX_SH    = $clog2(MTX_STRIDE),
    localparam int VEC_IDX_W = IDX_W - LANE_SH,
    localparam int MTX_IDX_W = IDX_W - MTX_SH
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        view,
    input  logic [IDX_W-1:0]                  idx,
    output logic [LANES-1:0][IDX_W-1:0]       lane_addr,
    output logic [LANES-1:0]                  lane_en,
    output logic [LANES-1:0][LANE_SH-1:0]     lane_slot
);

    fp_view_e           view_e;
    logic [IDX_W-1:0]   base;
    logic [LANE_SH:0]   n_active;

    assign view_e = fp_view_e'(view);

    // Purpose: pick the base word and the number of active lanes for the view.
    always_comb begin
        base     = idx;
        n_active = (LANE_SH+1)'(1);
        case (view_e)
            VIEW_SINGLE: begin
                base     = idx;
                n_active = (LANE_SH+1)'(1);
            end
            VIEW_DOUBLE: begin
                base     = idx;
                n_active = (LANE_SH+1)'(2);
            end
            VIEW_VECTOR: begin
                base     = {idx[VEC_IDX_W-1:0], {LANE_SH{1'b0}}};
                n_active = (LANE_SH+1)'(LANES);
            end
            VIEW_MATRIX: begin
                base     = {idx[MTX_IDX_W-1:0], {MTX_SH{1'b0}}};
                n_active = (LANE_SH+1)'(1);
            end
            default: begin
                base     = idx;
                n_active = (LANE_SH+1)'(1);
            end
        endcase
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [IDX_W-1:0]   K_OFS = IDX_W'(k);
        localparam logic [LANE_SH:0]   K_CNT = (LANE_SH+1)'(k);
        logic [LANE_SH:0] slot_full;

        // Purpose: consecutive address that wraps, enable, and slot position of lane k.
        always_comb begin
            lane_addr[k] = base + K_OFS;
            lane_en[k]   = (K_CNT < n_active);
            slot_full    = n_active - K_CNT - (LANE_SH+1)'(1);
            lane_slot[k] = slot_full[LANE_SH-1:0];
        end
    end

    // R6: a double at the top index pairs with word 0
    a_r6_double_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (view == 2'd1 && idx == IDX_W'(NUM_REGS-1)) |-> (lane_addr[1] == '0 && lane_en[1]));

    // R7: a vector base is aligned to LANES and all lanes are active
    a_r7_vector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (view == 2'd2) |-> (lane_addr[0][LANE_SH-1:0] == '0 && lane_en == '1));

    // R9: a matrix base is aligned to MTX_STRIDE and exactly one lane is active
    a_r9_matrix_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (view == 2'd3) |-> (lane_addr[0][MTX_SH-1:0] == '0 && $countones(lane_en) == 1));

    // R2: a single access uses lane 0 alone, in slot 0
    a_r2_single_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (view == 2'd0) |-> (lane_addr[0] == idx && lane_en == LANES'(1) && lane_slot[0] == '0));

endmodule : fprf_lane_map

// File: rtl/fprf_bank.sv
// Module: fprf_bank
// Storage array of NUM_REGS words. It takes up to LANES word writes per clock
// from one write access and gives LANES combinational read words.
// Assumes the enabled write lanes carry distinct addresses, which the lane
// map guarantees. Synchronous active-low reset clears every word.
module fprf_bank #(
    parameter int NUM_REGS = 64,
    parameter int WORD_W   = 32,
    parameter int LANES    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [LANES-1:0]              wr_lane_en,
    input  logic [LANES-1:0][IDX_W-1:0]   wr_lane_addr,
    input  logic [LANES-1:0][WORD_W-1:0]  wr_lane_word,
    input  logic [LANES-1:0][IDX_W-1:0]   rd_lane_addr,
    output logic [LANES-1:0][WORD_W-1:0]  rd_lane_word
);

    logic [WORD_W-1:0] mem_q [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        localparam logic [IDX_W-1:0] R_ADDR = IDX_W'(r);
        logic              hit;
        logic [WORD_W-1:0] nxt;

        // Purpose: find which lane, if any, writes word r in this cycle.
        always_comb begin
            hit = 1'b0;
            nxt = mem_q[r];
            for (int k = 0; k < LANES; k++) begin
                if (wr_en && wr_lane_en[k] && wr_lane_addr[k] == R_ADDR) begin
                    hit = 1'b1;
                    nxt = wr_lane_word[k];
                end
            end
        end

        // Purpose: hold word r, clear it on reset, load it on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[r] <= '0;
            end else if (hit) begin
                mem_q[r] <= nxt;
            end
        end

        // R12: with the write strobe low the word keeps its value
        a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(mem_q[r]));
    end

    for (genvar k = 0; k < LANES; k++) begin : g_rd
        // Purpose: combinational read of the word addressed by lane k.
        always_comb begin
            rd_lane_word[k] = mem_q[rd_lane_addr[k]];
        end

        // R3: an enabled write lane lands its word at the next edge
        a_r3_lane_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_lane_en[k]) |=> (mem_q[$past(wr_lane_addr[k])] == $past(wr_lane_word[k])));
    end

endmodule : fprf_bank

// File: rtl/fprf_read_pack.sv
// Module: fprf_read_pack
// Places the words of the enabled read lanes into their slots of the read
// bus and zeroes the unused slots. Assumes the enabled lanes use distinct slots.
module fprf_read_pack #(
    parameter int WORD_W  = 32,
    parameter int LANES   = 4,
    localparam int LANE_SH = $clog2(LANES),
    localparam int BUS_W   = LANES * WORD_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    view,
    input  logic [LANES-1:0]              lane_en,
    input  logic [LANES-1:0][LANE_SH-1:0] lane_slot,
    input  logic [LANES-1:0][WORD_W-1:0]  lane_word,
    output logic [BUS_W-1:0]              data
);

    // Purpose: build the read bus slot by slot from the enabled lanes.
    always_comb begin
        data = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane_en[k]) begin
                data[int'(lane_slot[k])*WORD_W +: WORD_W] = lane_word[k];
            end
        end
    end

    // R2: a single read leaves every slot above slot 0 at zero
    a_r2_single_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (view == 2'd0) |-> (data[BUS_W-1:WORD_W] == '0));

    // R4: a double read leaves every slot above slot 1 at zero
    a_r4_double_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (view == 2'd1) |-> (data[BUS_W-1:2*WORD_W] == '0));

    // R9: a matrix read leaves every slot above slot 0 at zero
    a_r9_matrix_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (view == 2'd3) |-> (data[BUS_W-1:WORD_W] == '0));

endmodule : fprf_read_pack

// File: rtl/fp_multiview_regfile.sv
// Module: fp_multiview_regfile
// A 64-word register file reached through single, double, vector and matrix
// views. It has one synchronous write port and one combinational read port,
// and each port has its own view select. Assumes power-of-two sizes and a
// bus width of LANES words.
module fp_multiview_regfile #(
    parameter int NUM_REGS   = 64,
    parameter int WORD_W     = 32,
    parameter int LANES      = 4,
    parameter int MTX_STRIDE = 16,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int LANE_SH   = $clog2(LANES),
    localparam int BUS_W     = LANES * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_view,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [1:0]        rd_view,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BUS_W-1:0]  rd_data
);

    logic [LANES-1:0][IDX_W-1:0]   wr_lane_addr;
    logic [LANES-1:0]              wr_lane_en;
    logic [LANES-1:0][LANE_SH-1:0] wr_lane_slot;
    logic [LANES-1:0][WORD_W-1:0]  wr_lane_word;
    logic [LANES-1:0][IDX_W-1:0]   rd_lane_addr;
    logic [LANES-1:0]              rd_lane_en;
    logic [LANES-1:0][LANE_SH-1:0] rd_lane_slot;
    logic [LANES-1:0][WORD_W-1:0]  rd_lane_word;

    fprf_lane_map #(
        .NUM_REGS   (NUM_REGS),
        .LANES      (LANES),
        .MTX_STRIDE (MTX_STRIDE)
    ) i_wr_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .view      (wr_view),
        .idx       (wr_idx),
        .lane_addr (wr_lane_addr),
        .lane_en   (wr_lane_en),
        .lane_slot (wr_lane_slot)
    );

    fprf_lane_map #(
        .NUM_REGS   (NUM_REGS),
        .LANES      (LANES),
        .MTX_STRIDE (MTX_STRIDE)
    ) i_rd_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .view      (rd_view),
        .idx       (rd_idx),
        .lane_addr (rd_lane_addr),
        .lane_en   (rd_lane_en),
        .lane_slot (rd_lane_slot)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_wr_split
        // Purpose: give write lane k the data slot the lane map assigns to it.
        always_comb begin
            wr_lane_word[k] = wr_data[int'(wr_lane_slot[k])*WORD_W +: WORD_W];
        end
    end

    fprf_bank #(
        .NUM_REGS (NUM_REGS),
        .WORD_W   (WORD_W),
        .LANES    (LANES)
    ) i_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_lane_en   (wr_lane_en),
        .wr_lane_addr (wr_lane_addr),
        .wr_lane_word (wr_lane_word),
        .rd_lane_addr (rd_lane_addr),
        .rd_lane_word (rd_lane_word)
    );

    fprf_read_pack #(
        .WORD_W (WORD_W),
        .LANES  (LANES)
    ) i_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .view      (rd_view),
        .lane_en   (rd_lane_en),
        .lane_slot (rd_lane_slot),
        .lane_word (rd_lane_word),
        .data      (rd_data)
    );

    // R11: with no write pending and steady read inputs the read result stays put
    a_r11_read_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!wr_en) && $stable(rd_view) && $stable(rd_idx)) |-> $stable(rd_data));

endmodule : fp_multiview_regfile

// File: tb/test_fp_multiview_regfile.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked against a
// word-level model kept in the bench.
module test_fp_multiview_regfile;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [1:0]   wr_view;
    logic [5:0]   wr_idx;
    logic [127:0] wr_data;
    logic [1:0]   rd_view;
    logic [5:0]   rd_idx;
    logic [127:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] model [64];

    always #5 clk = ~clk;

    fp_multiview_regfile i_fp_multiview_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_view (wr_view),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_view (rd_view),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    function automatic logic [127:0] expect_read(logic [1:0] v, logic [5:0] i);
        logic [5:0] b;
        case (v)
            2'd0: return {96'b0, model[i]};
            2'd1: return {64'b0, model[i], model[i + 6'd1]};
            2'd2: begin
                b = {i[3:0], 2'b00};
                return {model[b], model[b + 6'd1], model[b + 6'd2], model[b + 6'd3]};
            end
            default: begin
                b = {i[1:0], 4'b0000};
                return {96'b0, model[b]};
            end
        endcase
    endfunction

    function automatic void model_write(logic [1:0] v, logic [5:0] i, logic [127:0] d);
        logic [5:0] b;
        case (v)
            2'd0: model[i] = d[31:0];
            2'd1: begin
                model[i]        = d[63:32];
                model[i + 6'd1] = d[31:0];
            end
            2'd2: begin
                b = {i[3:0], 2'b00};
                model[b]        = d[127:96];
                model[b + 6'd1] = d[95:64];
                model[b + 6'd2] = d[63:32];
                model[b + 6'd3] = d[31:0];
            end
            default: begin
                b = {i[1:0], 4'b0000};
                model[b] = d[31:0];
            end
        endcase
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_check(string req, logic [1:0] v, logic [5:0] i);
        @(negedge clk);
        rd_view = v;
        rd_idx  = i;
        #1;
        check(req, rd_data, expect_read(v, i));
    endtask

    task automatic do_write(logic [1:0] v, logic [5:0] i, logic [127:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_view = v;
        wr_idx  = i;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model_write(v, i, d);
    endtask

    function automatic string tag_for(logic [1:0] v);
        case (v)
            2'd0: return "R2";
            2'd1: return "R4";
            2'd2: return "R7";
            default: return "R9";
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst_n = 1'b0; wr_en = 1'b0; wr_view = '0; wr_idx = '0; wr_data = '0;
        rd_view = '0; rd_idx = '0;
        for (int k = 0; k < 64; k++) model[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every word is zero after reset
        for (int k = 0; k < 64; k++) read_check("R1", 2'd0, 6'(k));

        // R3: a single write takes the low word only, the neighbours stay
        do_write(2'd0, 6'd5, {96'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF, 32'hA5A5_0001});
        read_check("R3", 2'd0, 6'd5);
        read_check("R3", 2'd0, 6'd4);
        read_check("R3", 2'd0, 6'd6);
        check("R3", rd_data, 128'h0);

        // R5 and R4: a double write splits its halves, a double read joins them
        do_write(2'd1, 6'd10, {64'hFFFF_FFFF_FFFF_FFFF, 32'h1111_2222, 32'h3333_4444});
        read_check("R5", 2'd0, 6'd10);
        check("R5", rd_data, {96'b0, 32'h1111_2222});
        read_check("R5", 2'd0, 6'd11);
        check("R5", rd_data, {96'b0, 32'h3333_4444});
        read_check("R4", 2'd1, 6'd10);

        // R6: a double at index 63 wraps to word 0
        do_write(2'd1, 6'd63, {64'b0, 32'h6363_6363, 32'h0000_0B0B});
        read_check("R6", 2'd0, 6'd0);
        check("R6", rd_data, {96'b0, 32'h0000_0B0B});
        read_check("R6", 2'd1, 6'd63);
        check("R6", rd_data, {64'b0, 32'h6363_6363, 32'h0000_0B0B});

        // R8 and R7: index 17 is masked to 1, giving base 4
        do_write(2'd2, 6'd17, {32'h4444_0004, 32'h5555_0005, 32'h6666_0006, 32'h7777_0007});
        read_check("R8", 2'd0, 6'd4);
        check("R8", rd_data, {96'b0, 32'h4444_0004});
        read_check("R8", 2'd0, 6'd7);
        check("R8", rd_data, {96'b0, 32'h7777_0007});
        read_check("R7", 2'd2, 6'd1);
        read_check("R7", 2'd2, 6'd17);
        check("R7", rd_data, {32'h4444_0004, 32'h5555_0005, 32'h6666_0006, 32'h7777_0007});

        // R10 and R9: index 6 is masked to 2, giving base 32
        do_write(2'd3, 6'd6, {96'hABCD_ABCD_ABCD_ABCD_ABCD_ABCD, 32'h3232_3232});
        read_check("R10", 2'd0, 6'd32);
        check("R10", rd_data, {96'b0, 32'h3232_3232});
        read_check("R10", 2'd0, 6'd33);
        check("R10", rd_data, 128'h0);
        read_check("R9", 2'd3, 6'd2);
        read_check("R9", 2'd3, 6'd6);

        // R12: the write inputs toggle with the strobe low and nothing moves
        @(negedge clk);
        wr_en = 1'b0; wr_view = 2'd2; wr_idx = 6'd1; wr_data = {4{32'h9999_9999}};
        @(posedge clk);
        #1;
        read_check("R12", 2'd2, 6'd1);
        read_check("R12", 2'd0, 6'd5);

        // R11: a same-cycle read sees the old word, then the new one after the edge
        @(negedge clk);
        wr_en = 1'b1; wr_view = 2'd0; wr_idx = 6'd20; wr_data = {96'b0, 32'h2020_2020};
        rd_view = 2'd0; rd_idx = 6'd20;
        #1;
        check("R11", rd_data, expect_read(2'd0, 6'd20));
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model_write(2'd0, 6'd20, {96'b0, 32'h2020_2020});
        check("R11", rd_data, {96'b0, 32'h2020_2020});

        // Random mixed traffic across all views
        for (int n = 0; n < 600; n++) begin
            logic [1:0]   v;
            logic [5:0]   i;
            logic [127:0] d;
            v = 2'($urandom_range(0, 3));
            i = 6'($urandom_range(0, 63));
            d = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(0, 3) != 0) begin
                do_write(v, i, d);
            end else begin
                @(negedge clk);
                wr_en = 1'b0; wr_view = v; wr_idx = i; wr_data = d;
                @(posedge clk);
                #1;
            end
            v = 2'($urandom_range(0, 3));
            i = 6'($urandom_range(0, 63));
            read_check(tag_for(v), v, i);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule : test_fp_multiview_regfile